// File: doc/BRIEF.md
# Scatter-Gather Descriptor Walker

This block is the front end of a scatter-gather DMA channel. After a start pulse it takes a 32-bit table base address and reads 64-bit descriptor lines one at a time through a simple memory read port. For each line that describes a data transfer, it passes the line's buffer address and byte count to a downstream data mover. It then waits for the mover to report completion before it reads the next line. The walk ends on a line whose end flag is set, and the block reports completion. If the walk reaches a line whose valid flag is clear, it stops at once and reports an error.

Software builds each table by cutting a large buffer into full 65536-byte lines followed by one final line that holds the remainder. A length field of zero therefore means 65536 bytes. Lines whose action code is not the data code are skipped. If such a line carries the end flag, it still ends the walk.

Top module: `adma_walker`

## Requirements
- R1: After reset, busy_o, done_o, err_o, desc_rd_req_o and mv_req_o are all 0.
- R2: A start_i pulse seen while the walker is idle loads base_addr_i, and the first descriptor read goes to that address. A start_i seen while busy has no effect.
- R3: A descriptor line holds the attribute field in bits [15:0], the length in bits [31:16] and the buffer address in bits [63:32]. In the attribute field, bit 0 is valid, bit 1 is end, and bits [5:4] are the action code, where 2'b10 means a data transfer.
- R4: A valid data line produces exactly one mover request carrying that line's address and length. The request is held with stable values until mv_done_i, and no descriptor read is issued while it is outstanding.
- R5: A length field of 0 is presented on mv_len_o as 65536. Any other value is presented unchanged.
- R6: Each following descriptor read address is 8 greater than the one before.
- R7: A data line with the end flag set ends the walk in the cycle its transfer completes. done_o then rises and busy_o falls.
- R8: A line whose valid flag is 0 raises err_o, issues no mover request and ends the walk, with done_o left at 0.
- R9: A valid line with a non-data action code issues no request. Without the end flag the walk moves on to the next line; with the end flag the walk ends with done_o set.
- R10: done_o and err_o hold their value until the next accepted start, which clears both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a walk (accepted only when idle) |
| base_addr_i | input | 32 | Descriptor table base address |
| desc_rd_req_o | output | 1 | Descriptor read request, held until valid |
| desc_rd_addr_o | output | 32 | Descriptor read address |
| desc_rd_valid_i | input | 1 | Descriptor read data valid |
| desc_rd_data_i | input | 64 | Descriptor line |
| mv_req_o | output | 1 | Transfer request to the data mover |
| mv_addr_o | output | 32 | Transfer buffer address |
| mv_len_o | output | 17 | Transfer byte count (1 to 65536) |
| mv_done_i | input | 1 | Transfer complete pulse from the mover |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | Last walk ended normally |
| err_o | output | 1 | Last walk hit an invalid line |

## Verification
The collision that matters is a new start_i arriving in the same cycle as the mover's final completion on an end line. At that edge the walker is still busy, so the start must be dropped rather than restart the walk. The bench provokes this by having the mover model raise start_i together with mv_done_i. It then judges the result at the ports: done_o must read 1, busy_o must return to 0, and no further descriptor read may appear. A separate, later start must then clear done_o and run normally.

// File: rtl/adma_walk_pkg.sv
package adma_walk_pkg;
   typedef enum logic [1:0] {
      WS_IDLE  = 2'd0,
      WS_FETCH = 2'd1,
      WS_MOVE  = 2'd2
   } walk_st_e;

   localparam int unsigned ATTR_VLD_BIT = 0;
   localparam int unsigned ATTR_END_BIT = 1;
   localparam int unsigned ATTR_ACT_LSB = 4;
   localparam logic [1:0]  ACT_DATA     = 2'b10;
endpackage

// File: rtl/adma_desc_decode.sv
module adma_desc_decode #(
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned LEN_W       = 16,
   parameter int unsigned ATTR_W      = 16,
   parameter bit          ZERO_IS_MAX = 1'b1,
   localparam int unsigned DESC_W     = ATTR_W + LEN_W + ADDR_W
) (
   input  logic [DESC_W-1:0] line_i,
   output logic              vld_o,
   output logic              end_o,
   output logic              is_data_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [LEN_W:0]    len_o
);
   import adma_walk_pkg::*;

   localparam int unsigned LEN_LSB  = ATTR_W;
   localparam int unsigned ADDR_LSB = ATTR_W + LEN_W;

   generate
      if (ATTR_W < ATTR_ACT_LSB + 2) begin : g_attr_too_narrow
         $error("attribute field too narrow for action code");
      end
   endgenerate

   logic [LEN_W-1:0] raw_len;

   assign vld_o     = line_i[ATTR_VLD_BIT];
   assign end_o     = line_i[ATTR_END_BIT];
   assign is_data_o = (line_i[ATTR_ACT_LSB +: 2] == ACT_DATA);
   assign addr_o    = line_i[ADDR_LSB +: ADDR_W];
   assign raw_len   = line_i[LEN_LSB +: LEN_W];

   generate
      if (ZERO_IS_MAX) begin : g_len_wrap
         always_comb begin
            if (raw_len == '0) len_o = {1'b1, {LEN_W{1'b0}}};
            else               len_o = {1'b0, raw_len};
         end
      end else begin : g_len_plain
         assign len_o = {1'b0, raw_len};
      end
   endgenerate
endmodule

// File: rtl/adma_ptr.sv
module adma_ptr #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned STEP   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic              adv_i,
   output logic [ADDR_W-1:0] ptr_o
);
   localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

   generate
      if (STEP == 0) begin : g_bad_step
         $error("descriptor step must be nonzero");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ptr_o <= '0;
      else if (load_i) ptr_o <= base_i;
      else if (adv_i)  ptr_o <= ptr_o + STEP_V;
   end

   // R6
   ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_i && !load_i) |=> (ptr_o == $past(ptr_o) + STEP_V));
endmodule

// File: rtl/adma_walker.sv
module adma_walker #(
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned LEN_W       = 16,
   parameter int unsigned ATTR_W      = 16,
   parameter bit          ZERO_IS_MAX = 1'b1,
   localparam int unsigned DESC_W     = ATTR_W + LEN_W + ADDR_W,
   localparam int unsigned STEP       = DESC_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] base_addr_i,
   output logic              desc_rd_req_o,
   output logic [ADDR_W-1:0] desc_rd_addr_o,
   input  logic              desc_rd_valid_i,
   input  logic [DESC_W-1:0] desc_rd_data_i,
   output logic              mv_req_o,
   output logic [ADDR_W-1:0] mv_addr_o,
   output logic [LEN_W:0]    mv_len_o,
   input  logic              mv_done_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              err_o
);
   import adma_walk_pkg::*;

   generate
      if (DESC_W % 8 != 0) begin : g_bad_line
         $error("descriptor line must be whole bytes");
      end
   endgenerate

   walk_st_e          st_q;
   logic              d_vld, d_end, d_data;
   logic [ADDR_W-1:0] d_addr;
   logic [LEN_W:0]    d_len;
   logic              end_q;
   logic              accept, adv;

   adma_desc_decode #(
      .ADDR_W(ADDR_W), .LEN_W(LEN_W), .ATTR_W(ATTR_W), .ZERO_IS_MAX(ZERO_IS_MAX)
   ) u_dec (
      .line_i(desc_rd_data_i), .vld_o(d_vld), .end_o(d_end), .is_data_o(d_data),
      .addr_o(d_addr), .len_o(d_len)
   );

   assign accept = start_i && (st_q == WS_IDLE);
   assign adv    = ((st_q == WS_FETCH) && desc_rd_valid_i && d_vld && !d_data && !d_end)
                 || ((st_q == WS_MOVE) && mv_done_i && !end_q);

   adma_ptr #(.ADDR_W(ADDR_W), .STEP(STEP)) u_ptr (
      .clk(clk), .rst_n(rst_n), .load_i(accept), .base_i(base_addr_i),
      .adv_i(adv), .ptr_o(desc_rd_addr_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= WS_IDLE;
         end_q     <= 1'b0;
         mv_addr_o <= '0;
         mv_len_o  <= '0;
         done_o    <= 1'b0;
         err_o     <= 1'b0;
      end else begin
         case (st_q)
            WS_IDLE: begin
               if (accept) begin
                  st_q   <= WS_FETCH;
                  done_o <= 1'b0;
                  err_o  <= 1'b0;
               end
            end
            WS_FETCH: begin
               if (desc_rd_valid_i) begin
                  if (!d_vld) begin
                     err_o <= 1'b1;
                     st_q  <= WS_IDLE;
                  end else if (d_data) begin
                     mv_addr_o <= d_addr;
                     mv_len_o  <= d_len;
                     end_q     <= d_end;
                     st_q      <= WS_MOVE;
                  end else if (d_end) begin
                     done_o <= 1'b1;
                     st_q   <= WS_IDLE;
                  end
               end
            end
            WS_MOVE: begin
               if (mv_done_i) begin
                  if (end_q) begin
                     done_o <= 1'b1;
                     st_q   <= WS_IDLE;
                  end else begin
                     st_q <= WS_FETCH;
                  end
               end
            end
            default: st_q <= WS_IDLE;
         endcase
      end
   end

   assign desc_rd_req_o = (st_q == WS_FETCH);
   assign mv_req_o      = (st_q == WS_MOVE);
   assign busy_o        = (st_q != WS_IDLE);

   // R4
   req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(mv_req_o && desc_rd_req_o));
   // R4
   mv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mv_req_o && !mv_done_i) |=> (mv_req_o && $stable(mv_addr_o) && $stable(mv_len_o)));
   // R8
   err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_o) |-> ($past(desc_rd_valid_i) && !busy_o && !done_o));
   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (!mv_req_o && !desc_rd_req_o));
   // R10
   status_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && err_o));
endmodule

// File: tb/adma_walker_tb_top.sv
module adma_walker_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [31:0] base_addr_i = '0;
   logic        desc_rd_req_o;
   logic [31:0] desc_rd_addr_o;
   logic        desc_rd_valid_i = 1'b0;
   logic [63:0] desc_rd_data_i = '0;
   logic        mv_req_o;
   logic [31:0] mv_addr_o;
   logic [16:0] mv_len_o;
   logic        mv_done_i = 1'b0;
   logic        busy_o, done_o, err_o;

   always #5 clk = ~clk;

   adma_walker dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_addr_i(base_addr_i),
      .desc_rd_req_o(desc_rd_req_o), .desc_rd_addr_o(desc_rd_addr_o),
      .desc_rd_valid_i(desc_rd_valid_i), .desc_rd_data_i(desc_rd_data_i),
      .mv_req_o(mv_req_o), .mv_addr_o(mv_addr_o), .mv_len_o(mv_len_o),
      .mv_done_i(mv_done_i), .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
   );

   localparam logic [15:0] A_VLD = 16'h0001, A_END = 16'h0002, A_DATA = 16'h0020;

   int checks = 0, fails = 0;
   logic [63:0] mem [0:63];
   logic [31:0] fetch_log [0:15];
   logic [31:0] xa [0:15];
   logic [16:0] xl [0:15];
   int nf = 0, nx = 0;
   bit start_on_done = 0;

   function automatic logic [63:0] mk(input logic [31:0] a, input logic [15:0] l,
                                      input logic [15:0] at);
      return {a, l, at};
   endfunction

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // descriptor memory: one-cycle response
   initial forever begin
      @(negedge clk);
      if (desc_rd_req_o && !desc_rd_valid_i) begin
         desc_rd_valid_i = 1'b1;
         desc_rd_data_i  = mem[desc_rd_addr_o[8:3]];
         if (nf < 16) fetch_log[nf] = desc_rd_addr_o;
         nf++;
      end else desc_rd_valid_i = 1'b0;
   end

   // data mover: completes two cycles after request seen
   initial begin
      int dly = 2;
      forever begin
         @(negedge clk);
         if (mv_done_i) begin
            mv_done_i = 1'b0;
            start_i   = 1'b0;
         end else if (mv_req_o) begin
            if (dly == 0) begin
               if (nx < 16) begin xa[nx] = mv_addr_o; xl[nx] = mv_len_o; end
               nx++;
               mv_done_i = 1'b1;
               if (start_on_done) begin start_i = 1'b1; start_on_done = 0; end
               dly = 2;
            end else dly--;
         end
      end
   end

   task automatic run(input logic [31:0] base);
      nf = 0; nx = 0;
      @(negedge clk);
      base_addr_i = base; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      for (int i = 0; i < 200 && busy_o; i++) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic t_reset;
      chk(!busy_o && !done_o && !err_o && !desc_rd_req_o && !mv_req_o, "R1 reset",
          {busy_o, done_o, err_o, desc_rd_req_o, mv_req_o}, 0);
   endtask

   task automatic t_single;
      mem[8] = mk(32'hA000_0000, 16'd512, A_VLD | A_END | A_DATA);
      run(32'h0000_1040);
      chk(fetch_log[0] == 32'h1040, "R2 first fetch at base", fetch_log[0], 32'h1040);
      chk(nx == 1, "R4 one request", nx, 1);
      chk(xa[0] == 32'hA000_0000, "R3 addr field", xa[0], 32'hA000_0000);
      chk(xl[0] == 17'd512, "R3 len field", xl[0], 512);
      chk(done_o && !busy_o && !err_o, "R7 done after end", {done_o, busy_o, err_o}, 3'b100);
   endtask

   task automatic t_chain;
      mem[16] = mk(32'h0010_0000, 16'd0,   A_VLD | A_DATA);
      mem[17] = mk(32'h0011_0000, 16'd0,   A_VLD | A_DATA);
      mem[18] = mk(32'h0012_0000, 16'd300, A_VLD | A_END | A_DATA);
      run(32'h0000_1080);
      chk(nx == 3, "R4 three requests", nx, 3);
      chk(xl[0] == 17'h10000, "R5 zero length is 65536", xl[0], 17'h10000);
      chk(xl[2] == 17'd300, "R5 remainder length", xl[2], 300);
      chk(xa[1] == 32'h0011_0000, "R4 second addr", xa[1], 32'h0011_0000);
      chk(fetch_log[1] == 32'h1088 && fetch_log[2] == 32'h1090, "R6 step of 8",
          fetch_log[2], 32'h1090);
      chk(nf == 3 && done_o, "R7 stop after end line", nf, 3);
   endtask

   task automatic t_skip;
      mem[24] = mk(32'hDEAD_0000, 16'd7,  A_VLD);
      mem[25] = mk(32'h0020_0000, 16'd64, A_VLD | A_DATA);
      mem[26] = mk(32'hBEEF_0000, 16'd9,  A_VLD | A_END | 16'h0010);
      mem[27] = mk(32'h0030_0000, 16'd1,  A_VLD | A_END | A_DATA);
      run(32'h0000_10C0);
      chk(nx == 1 && xa[0] == 32'h0020_0000, "R9 non-data lines skipped", nx, 1);
      chk(nf == 3, "R9 end on non-data line stops walk", nf, 3);
      chk(done_o && !err_o, "R9 done set", {done_o, err_o}, 2'b10);
   endtask

   task automatic t_invalid;
      mem[32] = mk(32'h0040_0000, 16'd16, A_VLD | A_DATA);
      mem[33] = mk(32'h0050_0000, 16'd16, A_END | A_DATA);
      run(32'h0000_1100);
      chk(nx == 1, "R8 no request for invalid line", nx, 1);
      chk(err_o && !done_o && !busy_o, "R8 error raised", {err_o, done_o, busy_o}, 3'b100);
      repeat (5) @(negedge clk);
      chk(err_o, "R10 error held", err_o, 1);
   endtask

   task automatic t_collide;
      mem[40] = mk(32'h0060_0000, 16'd32, A_VLD | A_END | A_DATA);
      start_on_done = 1;
      run(32'h0000_1140);
      repeat (6) @(negedge clk);
      chk(done_o && !busy_o && !err_o, "R2 start during final done ignored",
          {done_o, busy_o, err_o}, 3'b100);
      chk(nf == 1 && nx == 1, "R2 no extra fetch", nf, 1);
      // fresh start after error clears error
      run(32'h0000_1108);
      chk(err_o && !done_o, "R10 restart sets new status", {err_o, done_o}, 2'b10);
      run(32'h0000_1140);
      chk(done_o && !err_o && nx == 1, "R10 start clears error", {done_o, err_o}, 2'b10);
   endtask

   initial begin
      for (int i = 0; i < 64; i++) mem[i] = '0;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_single();
      t_chain();
      t_skip();
      t_invalid();
      t_collide();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #200000;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule